// File: doc/BRIEF.md
# Word Stack Sequencer over Byte Memory

This block runs a last-in first-out stack that lives in a byte-wide RAM. A 16-bit stack offset register points at the top of the stack; a 16-bit segment input places the stack in a 20-bit byte address space. Every transfer is a whole 16-bit word, moved as two single-byte memory cycles.

Four commands are supported: push one word, pop one word, push a group of eight register values, and pop that group back. A command is offered with `cmd_valid` and taken on any clock edge where `busy` is low. The block then owns the memory port for two byte cycles (single word) or sixteen byte cycles (group). Popped words come back one at a time on `pop_word` with a one-cycle `pop_valid` strobe and a slot number.

The RAM is read combinationally: `mem_rdata` must reflect `mem_addr` within the same cycle that `mem_re` is high.

Top module: `word_stack_engine`

## Requirements
- R1: A command is taken at a rising edge where `cmd_valid` is 1 and `busy` is 0. `busy` is then 1 for exactly 2 cycles for a single-word command and 16 cycles for a group command. A command offered while `busy` is 1 has no effect. Opcodes on `cmd_op`: 00 push word, 01 pop word, 10 push group, 11 pop group.
- R2: A single push writes the high byte of `cmd_word` at offset SP-1 in the first byte cycle and the low byte at SP-2 in the second. SP then drops by 2.
- R3: A single pop reads the low byte at offset SP in the first byte cycle and the high byte at SP+1 in the second. `pop_word` = {high,low} is presented with `pop_valid` high for that second cycle only, with `pop_idx` = 0. SP then rises by 2.
- R4: Every byte address is `seg_base`×16 plus the current byte offset, taken modulo 2^20.
- R5: Words come back in reverse order of pushing. Pushing 1000h, 2000h and 3000h and then popping three times yields 3000h, 2000h and 1000h.
- R6: A group push stores slots 0 to 7 of `regs_in` (slot i at bits 16i+15:16i) in ascending slot order. Slot 0 goes just below SP, and each word is stored high byte first. Slot 4 is replaced by the SP value from before the command. SP drops by 16 at the end, and stays unchanged while the command runs.
- R7: A group pop restores slots in descending order, 7 down to 0, with `pop_idx` giving the slot. The word read for slot 4 is discarded: no `pop_valid` is raised for it, and SP is not loaded from it. SP rises by 16.
- R8: Stack offset arithmetic wraps modulo 65536.
- R9: After reset SP equals parameter SP_RESET (0). `busy`, `mem_we`, `mem_re` and `pop_valid` are 0.
- R10: Each busy cycle performs exactly one byte access (`mem_we` xor `mem_re`). No access happens while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | Command opcode |
| cmd_word | input | 16 | Word for a single push |
| regs_in | input | 128 | Eight 16-bit slots for a group push |
| seg_base | input | 16 | Stack segment value |
| busy | output | 1 | Command in progress |
| sp_out | output | 16 | Current stack offset |
| mem_addr | output | 20 | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 8 | Byte read, same cycle |
| pop_valid | output | 1 | Popped word present |
| pop_word | output | 16 | Popped word |
| pop_idx | output | 3 | Slot of the popped word |

## Verification
The assertions check the cycle-level properties on every cycle. These are one byte access per busy cycle and none when idle, busy rising after a taken command, and the byte offset stepping down by one between push cycles and up by one between pop cycles. They also check that the stack offset holds still during a command, that popped words appear only on read cycles, and that the slot-4 word never surfaces during a group pop. Only the bench's scenarios can show which bytes land at which addresses under a given segment, the LIFO return order, the substitution of the old SP into slot 4, wrap-around at offset zero, and that a command offered while busy is dropped.

// File: rtl/stk_pkg.sv
package stk_pkg;

  localparam int STK_SP_W   = 16;
  localparam int STK_SEG_W  = 16;
  localparam int STK_BYTE_W = 8;
  localparam int STK_WORD_W = 2 * STK_BYTE_W;
  localparam int STK_ADDR_W = STK_SEG_W + 4;

  typedef enum logic [1:0] {
    OP_PUSH  = 2'b00,
    OP_POP   = 2'b01,
    OP_PUSHG = 2'b10,
    OP_POPG  = 2'b11
  } stk_op_e;

  // bit 0 selects read direction, bit 1 selects the eight-slot group
  function automatic logic op_is_read(input logic [1:0] op);
    return op[0];
  endfunction

  function automatic logic op_is_group(input logic [1:0] op);
    return op[1];
  endfunction

  // byte k of a push lands k+1 below the untouched stack offset
  function automatic logic [STK_SP_W-1:0] push_off(input logic [STK_SP_W-1:0] sp,
                                                    input logic [STK_SP_W-1:0] k);
    return sp - k - STK_SP_W'(1);
  endfunction

  // byte k of a pop is k above the untouched stack offset
  function automatic logic [STK_SP_W-1:0] pop_off(input logic [STK_SP_W-1:0] sp,
                                                   input logic [STK_SP_W-1:0] k);
    return sp + k;
  endfunction

  function automatic logic [STK_ADDR_W-1:0] lin_addr(input logic [STK_SEG_W-1:0] seg,
                                                      input logic [STK_SP_W-1:0]  off);
    return {seg, 4'b0000} + STK_ADDR_W'(off);
  endfunction

  function automatic logic [STK_SP_W-1:0] sp_next(input logic [STK_SP_W-1:0] sp,
                                                   input logic [1:0]          op,
                                                   input logic [STK_SP_W-1:0] nbytes);
    return op_is_read(op) ? sp + nbytes : sp - nbytes;
  endfunction

endpackage

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int NREGS = 8,
  localparam int CNT_W = $clog2(2 * NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  output logic             active,
  output logic             accept,
  output logic             last_byte,
  output logic [1:0]       op_q,
  output logic [CNT_W-1:0] byte_k
);

  localparam logic [CNT_W-1:0] GRP_LAST = CNT_W'(2 * NREGS - 1);
  localparam logic [CNT_W-1:0] ONE_LAST = CNT_W'(1);

  logic [CNT_W-1:0] lim;

  assign accept    = cmd_valid & ~active;
  assign lim       = op_is_group(op_q) ? GRP_LAST : ONE_LAST;
  assign last_byte = active && (byte_k == lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      op_q   <= OP_PUSH;
      byte_k <= '0;
    end else if (accept) begin
      active <= 1'b1;
      op_q   <= cmd_op;
      byte_k <= '0;
    end else if (active) begin
      if (last_byte) active <= 1'b0;
      else           byte_k <= byte_k + CNT_W'(1);
    end
  end

endmodule

// File: rtl/stk_addr_gen.sv
module stk_addr_gen
  import stk_pkg::*;
#(
  parameter int NREGS = 8,
  localparam int CNT_W = $clog2(2 * NREGS)
) (
  input  logic [STK_SP_W-1:0]   sp,
  input  logic [STK_SEG_W-1:0]  seg,
  input  logic [1:0]            op_q,
  input  logic [CNT_W-1:0]      byte_k,
  output logic [STK_SP_W-1:0]   stk_off,
  output logic [STK_ADDR_W-1:0] mem_addr
);

  logic [STK_SP_W-1:0] k_ext;

  assign k_ext    = STK_SP_W'(byte_k);
  assign stk_off  = op_is_read(op_q) ? pop_off(sp, k_ext) : push_off(sp, k_ext);
  assign mem_addr = lin_addr(seg, stk_off);

endmodule

// File: rtl/stk_datapath.sv
module stk_datapath
  import stk_pkg::*;
#(
  parameter int NREGS   = 8,
  parameter int SP_SLOT = 4,
  localparam int CNT_W  = $clog2(2 * NREGS),
  localparam int IDX_W  = $clog2(NREGS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        accept,
  input  logic [1:0]                  cmd_op,
  input  logic [STK_WORD_W-1:0]       cmd_word,
  input  logic [NREGS*STK_WORD_W-1:0] regs_in,
  input  logic [STK_SP_W-1:0]         sp,
  input  logic                        active,
  input  logic [1:0]                  op_q,
  input  logic [CNT_W-1:0]            byte_k,
  input  logic [STK_BYTE_W-1:0]       mem_rdata,
  output logic [STK_BYTE_W-1:0]       mem_wdata,
  output logic                        mem_we,
  output logic                        mem_re,
  output logic                        pop_valid,
  output logic [STK_WORD_W-1:0]       pop_word,
  output logic [IDX_W-1:0]            pop_idx
);

  logic [STK_WORD_W-1:0] wbuf [NREGS];
  logic [STK_BYTE_W-1:0] lo_q;
  logic [IDX_W-1:0]      word_j;
  logic [STK_WORD_W-1:0] cur_word;
  logic                  hi_rd;

  // capture the words to push at acceptance; slot SP_SLOT takes the live offset
  for (genvar g = 0; g < NREGS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wbuf[g] <= '0;
      end else if (accept) begin
        if (op_is_group(cmd_op)) begin
          if (g == SP_SLOT) wbuf[g] <= STK_WORD_W'(sp);
          else              wbuf[g] <= regs_in[g*STK_WORD_W +: STK_WORD_W];
        end else if (g == 0) begin
          wbuf[g] <= cmd_word;
        end
      end
    end
  end

  assign word_j   = byte_k[CNT_W-1:1];
  assign cur_word = wbuf[word_j];
  assign mem_we   = active & ~op_is_read(op_q);
  assign mem_re   = active &  op_is_read(op_q);
  // even byte cycles carry the high byte on a push
  assign mem_wdata = byte_k[0] ? cur_word[STK_BYTE_W-1:0]
                               : cur_word[STK_WORD_W-1:STK_BYTE_W];

  always_ff @(posedge clk) begin
    if (!rst_n)                    lo_q <= '0;
    else if (mem_re && !byte_k[0]) lo_q <= mem_rdata;
  end

  assign hi_rd     = mem_re & byte_k[0];
  assign pop_word  = {mem_rdata, lo_q};
  assign pop_idx   = op_is_group(op_q) ? IDX_W'(NREGS - 1) - word_j : '0;
  assign pop_valid = hi_rd & ~(op_is_group(op_q) && (pop_idx == IDX_W'(SP_SLOT)));

endmodule

// File: rtl/word_stack_engine.sv
module word_stack_engine
  import stk_pkg::*;
#(
  parameter int          NREGS    = 8,
  parameter int          SP_SLOT  = 4,
  parameter logic [15:0] SP_RESET = 16'h0000,
  localparam int         CNT_W    = $clog2(2 * NREGS),
  localparam int         IDX_W    = $clog2(NREGS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  input  logic [1:0]                  cmd_op,
  input  logic [STK_WORD_W-1:0]       cmd_word,
  input  logic [NREGS*STK_WORD_W-1:0] regs_in,
  input  logic [STK_SEG_W-1:0]        seg_base,
  output logic                        busy,
  output logic [STK_SP_W-1:0]         sp_out,
  output logic [STK_ADDR_W-1:0]       mem_addr,
  output logic [STK_BYTE_W-1:0]       mem_wdata,
  output logic                        mem_we,
  output logic                        mem_re,
  input  logic [STK_BYTE_W-1:0]       mem_rdata,
  output logic                        pop_valid,
  output logic [STK_WORD_W-1:0]       pop_word,
  output logic [IDX_W-1:0]            pop_idx
);

  localparam logic [STK_SP_W-1:0] GRP_BYTES = STK_SP_W'(2 * NREGS);
  localparam logic [STK_SP_W-1:0] ONE_BYTES = STK_SP_W'(2);

  logic                active;
  logic                accept;
  logic                last_byte;
  logic [1:0]          op_q;
  logic [CNT_W-1:0]    byte_k;
  logic [STK_SP_W-1:0] sp_q;
  logic [STK_SP_W-1:0] stk_off;
  logic [STK_SP_W-1:0] nbytes;

  stk_seq #(.NREGS(NREGS)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .active(active), .accept(accept), .last_byte(last_byte),
    .op_q(op_q), .byte_k(byte_k)
  );

  stk_addr_gen #(.NREGS(NREGS)) u_addr (
    .sp(sp_q), .seg(seg_base), .op_q(op_q), .byte_k(byte_k),
    .stk_off(stk_off), .mem_addr(mem_addr)
  );

  stk_datapath #(.NREGS(NREGS), .SP_SLOT(SP_SLOT)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cmd_op(cmd_op),
    .cmd_word(cmd_word), .regs_in(regs_in), .sp(sp_q), .active(active),
    .op_q(op_q), .byte_k(byte_k), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .pop_valid(pop_valid), .pop_word(pop_word), .pop_idx(pop_idx)
  );

  assign nbytes = op_is_group(op_q) ? GRP_BYTES : ONE_BYTES;

  // the offset moves once, when the final byte of a command completes
  always_ff @(posedge clk) begin
    if (!rst_n)         sp_q <= SP_RESET;
    else if (last_byte) sp_q <= sp_next(sp_q, op_q, nbytes);
  end

  assign busy   = active;
  assign sp_out = sp_q;

endmodule

// File: rtl/stk_chk.sv
module stk_chk #(
  parameter int SP_SLOT = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        busy,
  input logic        mem_we,
  input logic        mem_re,
  input logic        pop_valid,
  input logic [2:0]  pop_idx,
  input logic [1:0]  op_q,
  input logic        last_byte,
  input logic [15:0] stk_off,
  input logic [15:0] sp_out
);

  // R1
  take_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy);

  // R10
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones({mem_we, mem_re}) == 1));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re));

  // R2
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (stk_off == $past(stk_off) - 16'd1));

  // R3
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && $past(mem_re)) |-> (stk_off == $past(stk_off) + 16'd1));

  // R3
  pop_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> mem_re);

  // R7
  no_sp_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && op_q[1]) |-> (pop_idx != 3'(SP_SLOT)));

  // R6
  sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_byte) |=> $stable(sp_out));

endmodule

bind word_stack_engine stk_chk #(.SP_SLOT(SP_SLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy),
  .mem_we(mem_we), .mem_re(mem_re), .pop_valid(pop_valid), .pop_idx(pop_idx),
  .op_q(op_q), .last_byte(last_byte), .stk_off(stk_off), .sp_out(sp_out)
);

// File: tb/word_stack_engine_bench.sv
module word_stack_engine_bench;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_valid;
  logic [1:0]   cmd_op;
  logic [15:0]  cmd_word;
  logic [127:0] regs_in;
  logic [15:0]  seg_base;
  logic         busy;
  logic [15:0]  sp_out;
  logic [19:0]  mem_addr;
  logic [7:0]   mem_wdata;
  logic         mem_we;
  logic         mem_re;
  logic [7:0]   mem_rdata;
  logic         pop_valid;
  logic [15:0]  pop_word;
  logic [2:0]   pop_idx;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  word_stack_engine u_word_stack_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_word(cmd_word), .regs_in(regs_in), .seg_base(seg_base),
    .busy(busy), .sp_out(sp_out), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .pop_valid(pop_valid), .pop_word(pop_word), .pop_idx(pop_idx)
  );

  // byte RAM model, 4 KiB window on the low address bits
  logic [7:0] bmem [4096];
  assign mem_rdata = bmem[mem_addr[11:0]];

  int          wr_n, rd_n, pv_n, busy_n;
  logic [19:0] wr_a [32];
  logic [7:0]  wr_d [32];
  logic [19:0] rd_a [32];
  logic [15:0] pv_w [16];
  logic [2:0]  pv_i [16];

  always @(posedge clk) begin
    if (mem_we) begin
      bmem[mem_addr[11:0]] <= mem_wdata;
      if (wr_n < 32) begin wr_a[wr_n] <= mem_addr; wr_d[wr_n] <= mem_wdata; end
      wr_n <= wr_n + 1;
    end
    if (mem_re) begin
      if (rd_n < 32) rd_a[rd_n] <= mem_addr;
      rd_n <= rd_n + 1;
    end
    if (pop_valid) begin
      if (pv_n < 16) begin pv_w[pv_n] <= pop_word; pv_i[pv_n] <= pop_idx; end
      pv_n <= pv_n + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    @(negedge clk);
    wr_n = 0; rd_n = 0; pv_n = 0;
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [15:0] w);
    clear_logs();
    cmd_valid = 1'b1; cmd_op = op; cmd_word = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    busy_n = 0;
    while (busy) begin busy_n++; @(negedge clk); end
  endtask

  function automatic logic [15:0] slot_val(input int i);
    return 16'h1111 * 16'(i + 1);
  endfunction

  // {op, data, expected popped word, expected SP after}
  localparam logic [49:0] VEC [8] = '{
    {2'b00, 16'h1000, 16'h0000, 16'hFFFE},
    {2'b00, 16'h2000, 16'h0000, 16'hFFFC},
    {2'b00, 16'h3000, 16'h0000, 16'hFFFA},
    {2'b01, 16'h0000, 16'h3000, 16'hFFFC},
    {2'b01, 16'h0000, 16'h2000, 16'hFFFE},
    {2'b01, 16'h0000, 16'h1000, 16'h0000},
    {2'b00, 16'hA55A, 16'h0000, 16'hFFFE},
    {2'b01, 16'h0000, 16'hA55A, 16'h0000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) bmem[i] = 8'h00;
    wr_n = 0; rd_n = 0; pv_n = 0; busy_n = 0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_word = '0;
    regs_in = '0; seg_base = 16'h0100;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 busy", 32'(busy), 0);
    chk("R9 sp", 32'(sp_out), 0);
    chk("R9 strobes", 32'({mem_we, mem_re, pop_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 LIFO table, R1 busy length
    for (int v = 0; v < 8; v++) begin
      run_cmd(VEC[v][49:48], VEC[v][47:32]);
      chk("R1 busy cycles word", 32'(busy_n), 2);
      chk("R5 sp", 32'(sp_out), 32'(VEC[v][15:0]));
      if (VEC[v][48]) begin
        chk("R5 pop count", 32'(pv_n), 1);
        chk("R5 pop word", 32'(pv_w[0]), 32'(VEC[v][31:16]));
      end
    end

    // R2 R4 byte order and segment placement
    seg_base = 16'h2000;
    run_cmd(2'b00, 16'hBEEF);
    chk("R2 write count", 32'(wr_n), 2);
    chk("R4 first addr", 32'(wr_a[0]), 32'h2FFFF);
    chk("R2 first byte", 32'(wr_d[0]), 32'hBE);
    chk("R4 second addr", 32'(wr_a[1]), 32'h2FFFE);
    chk("R2 second byte", 32'(wr_d[1]), 32'hEF);
    chk("R2 sp", 32'(sp_out), 32'hFFFE);

    // R3 pop byte order
    run_cmd(2'b01, 16'h0);
    chk("R3 first read addr", 32'(rd_a[0]), 32'h2FFFE);
    chk("R3 second read addr", 32'(rd_a[1]), 32'h2FFFF);
    chk("R3 word", 32'(pv_w[0]), 32'hBEEF);
    chk("R3 idx", 32'(pv_i[0]), 0);
    chk("R3 sp", 32'(sp_out), 0);

    // R8 wrap: pop at offset 0 reads 0 and 1, push from 2 returns to 0
    bmem[12'h000] = 8'h34; bmem[12'h001] = 8'h12;
    run_cmd(2'b01, 16'h0);
    chk("R8 read addr", 32'(rd_a[0]), 32'h20000);
    chk("R8 word", 32'(pv_w[0]), 32'h1234);
    chk("R8 sp", 32'(sp_out), 32'h0002);
    run_cmd(2'b00, 16'h5678);
    chk("R8 push addr", 32'(wr_a[0]), 32'h20001);
    chk("R8 sp back", 32'(sp_out), 0);

    // R1 command offered while busy is dropped
    clear_logs();
    cmd_valid = 1'b1; cmd_op = 2'b00; cmd_word = 16'h1111;
    @(negedge clk);
    cmd_op = 2'b01; cmd_word = 16'h2222;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 ignored writes", 32'(wr_n), 2);
    chk("R1 ignored reads", 32'(rd_n), 0);
    chk("R1 ignored sp", 32'(sp_out), 32'hFFFE);

    // R6 group push
    for (int i = 0; i < 8; i++)
      regs_in[i*16 +: 16] = (i == 4) ? 16'hDEAD : slot_val(i);
    run_cmd(2'b10, 16'h0);
    chk("R1 busy cycles group", 32'(busy_n), 16);
    chk("R10 group writes", 32'(wr_n), 16);
    chk("R10 group reads", 32'(rd_n), 0);
    chk("R6 first addr", 32'(wr_a[0]), 32'h2FFFD);
    chk("R6 sp", 32'(sp_out), 32'hFFEE);
    for (int j = 0; j < 8; j++) begin
      logic [15:0] hoff, loff, w, e;
      hoff = 16'hFFFE - 16'(2*j) - 16'd1;
      loff = hoff - 16'd1;
      w = {bmem[hoff[11:0]], bmem[loff[11:0]]};
      e = (j == 4) ? 16'hFFFE : slot_val(j);
      chk("R6 stored slot", 32'(w), 32'(e));
    end

    // R7 group pop
    regs_in = '0;
    run_cmd(2'b11, 16'h0);
    chk("R10 popall reads", 32'(rd_n), 16);
    chk("R7 pop count", 32'(pv_n), 7);
    chk("R7 sp", 32'(sp_out), 32'hFFFE);
    for (int p = 0; p < 7; p++) begin
      int ei;
      ei = (p < 3) ? 7 - p : 6 - p;
      chk("R7 slot order", 32'(pv_i[p]), 32'(ei));
      chk("R7 slot word", 32'(pv_w[p]), 32'(slot_val(ei)));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule